// File: doc/BRIEF.md
# Performance Level Transition Sequencer

This block orders the two halves of a performance-level change: the supply voltage target and the clock selection. A workload monitor presents a new level index. The block compares that index with the level now in force and picks the direction of the change.

When the level goes up, the block raises the voltage target first. It then waits until the supply is measured as settled, and only then moves the clock selection up. When the level goes down, the clock selection drops at once. The voltage target follows, and the block waits for the supply to settle at its lower value.

A built-in voltage monitor watches signed error samples from the voltage loop. It declares the supply settled after enough consecutive samples fall inside a programmable window. It then raises a power-good flag. That flag drops on every change of the voltage target. After a one-time setting of the window, the block needs no software during a transition. It reports busy while a transition runs, and a one-cycle done pulse when the transition finishes.

Top module: `perf_level_sequencer`

## Requirements
- R1: While reset is high and after its release, vdd_target and clk_select are 0, power_good is 1, and busy and done are 0.
- R2: A higher level requested in idle appears on vdd_target two clock edges after the edge that accepts it, while clk_select still holds the old level.
- R3: On a rising change, clk_select takes the new level one edge after power_good rises, and never while power_good is low. done pulses on that same edge.
- R4: On a falling change, clk_select takes the new level two edges after acceptance while vdd_target keeps the old level. vdd_target takes the new level on the next edge.
- R5: A falling change finishes with done on the edge where power_good returns to 1. At that point vdd_target and clk_select both equal the requested level.
- R6: A valid sample counts as in-window when its two's-complement magnitude is at most settle_window, with the bound included. The supply is settled after SETTLE_N (default 4) consecutive in-window samples. Any valid out-of-window sample restarts the count.
- R7: power_good goes to 0 on the edge where vdd_target changes. It stays 0 until the settle condition is met.
- R8: A request for the current level gives a done pulse one edge after acceptance, with no change on vdd_target, clk_select or power_good.
- R9: Requests presented while busy is 1 are ignored. They cause no extra done pulse and no change of the outputs.
- R10: busy is 1 from the edge after acceptance until the done edge. done is a single-cycle pulse and is never high together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New level request strobe |
| req_level | input | LVL_W | Requested performance level index |
| err_valid | input | 1 | Loop error sample valid |
| err_sample | input | ERR_W | Signed loop error sample |
| settle_window | input | ERR_W | Allowed error magnitude for settling (configuration) |
| vdd_target | output | LVL_W | Voltage target level sent to the regulator loop |
| clk_select | output | LVL_W | Clock selection level |
| power_good | output | 1 | Supply settled at the present target |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle pulse when a transition finishes |

## Verification
The bench holds the error outside the window during a rise. A design that let the clock ride up on a timer, instead of on the measured flag, would raise clk_select while power_good is still low.

The bench also breaks a run of in-window samples with one sample just past the bound. A monitor that pauses its count instead of restarting it would report settled too early. Errors of exactly plus and minus the window are fed to catch an off-by-one or a sign error in the magnitude test.

A request is injected in the middle of a falling transition. A sequencer that accepted it would give an extra done pulse or end at the wrong level. A same-level request must finish without disturbing power_good.

// File: rtl/perf_seq_pkg.sv
package perf_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAISE_V,
    ST_WAIT_GOOD,
    ST_SWITCH_CLK,
    ST_SWITCH_CLK_DN,
    ST_LOWER_V,
    ST_WAIT_SETTLE_DN
  } seq_state_t;

endpackage

// File: rtl/settle_monitor.sv
module settle_monitor #(
  parameter int ERR_W    = 8,
  parameter int SETTLE_N = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    sample_valid,
  input  logic signed [ERR_W-1:0] sample,
  input  logic        [ERR_W-1:0] window,
  output logic                    settled
);

  localparam int CNT_W = $clog2(SETTLE_N + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SETTLE_N);

  logic signed [ERR_W:0] sample_ext;
  logic        [ERR_W:0] magnitude;
  logic                  in_window;
  logic [CNT_W-1:0]      run_cnt;

  // One extra bit so the most negative sample has a representable magnitude.
  always_comb begin
    sample_ext = {sample[ERR_W-1], sample};
    magnitude  = sample_ext[ERR_W] ? $unsigned(-sample_ext) : $unsigned(sample_ext);
    in_window  = (magnitude <= {1'b0, window});
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_cnt <= '0;
    end else if (sample_valid) begin
      if (!in_window)
        run_cnt <= '0;
      else if (run_cnt != CNT_LIMIT)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  assign settled = (run_cnt == CNT_LIMIT);

endmodule

// File: rtl/transition_fsm.sv
module transition_fsm
  import perf_seq_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LVL_W-1:0] req_level,
  input  logic             settled,
  output logic             monitor_clear,
  output logic [LVL_W-1:0] vdd_target,
  output logic [LVL_W-1:0] clk_select,
  output logic             power_good,
  output logic             busy,
  output logic             done
);

  seq_state_t       state;
  logic [LVL_W-1:0] cur_level;
  logic [LVL_W-1:0] tgt_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_level  <= '0;
      tgt_level  <= '0;
      vdd_target <= '0;
      clk_select <= '0;
      power_good <= 1'b1;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            tgt_level <= req_level;
            if (req_level == cur_level)
              done <= 1'b1;
            else if (req_level > cur_level)
              state <= ST_RAISE_V;
            else
              state <= ST_SWITCH_CLK_DN;
          end
        end
        ST_RAISE_V: begin
          vdd_target <= tgt_level;
          power_good <= 1'b0;
          state      <= ST_WAIT_GOOD;
        end
        ST_WAIT_GOOD: begin
          if (settled) begin
            power_good <= 1'b1;
            state      <= ST_SWITCH_CLK;
          end
        end
        ST_SWITCH_CLK: begin
          clk_select <= tgt_level;
          cur_level  <= tgt_level;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        ST_SWITCH_CLK_DN: begin
          clk_select <= tgt_level;
          state      <= ST_LOWER_V;
        end
        ST_LOWER_V: begin
          vdd_target <= tgt_level;
          power_good <= 1'b0;
          state      <= ST_WAIT_SETTLE_DN;
        end
        ST_WAIT_SETTLE_DN: begin
          if (settled) begin
            power_good <= 1'b1;
            cur_level  <= tgt_level;
            done       <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // The settle count restarts on the same edge that moves the voltage target.
  assign monitor_clear = (state == ST_RAISE_V) || (state == ST_LOWER_V);
  assign busy          = (state != ST_IDLE);

endmodule

// File: rtl/perf_level_sequencer.sv
module perf_level_sequencer #(
  parameter int LVL_W    = 3,
  parameter int ERR_W    = 8,
  parameter int SETTLE_N = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [LVL_W-1:0]        req_level,
  input  logic                    err_valid,
  input  logic signed [ERR_W-1:0] err_sample,
  input  logic [ERR_W-1:0]        settle_window,
  output logic [LVL_W-1:0]        vdd_target,
  output logic [LVL_W-1:0]        clk_select,
  output logic                    power_good,
  output logic                    busy,
  output logic                    done
);

  logic settle_ok;
  logic settle_clear;

  settle_monitor #(
    .ERR_W    (ERR_W),
    .SETTLE_N (SETTLE_N)
  ) u_settle (
    .clk          (clk),
    .rst          (rst),
    .clear        (settle_clear),
    .sample_valid (err_valid),
    .sample       (err_sample),
    .window       (settle_window),
    .settled      (settle_ok)
  );

  transition_fsm #(
    .LVL_W (LVL_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_level     (req_level),
    .settled       (settle_ok),
    .monitor_clear (settle_clear),
    .vdd_target    (vdd_target),
    .clk_select    (clk_select),
    .power_good    (power_good),
    .busy          (busy),
    .done          (done)
  );

endmodule

// File: rtl/perf_level_sequencer_chk.sv
module perf_level_sequencer_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [LVL_W-1:0] vdd_target,
  input logic [LVL_W-1:0] clk_select,
  input logic             power_good,
  input logic             busy,
  input logic             done,
  input logic             settle_ok
);

  p_clk_up_after_good_r3: assert property (@(posedge clk) disable iff (rst)
    (clk_select > $past(clk_select)) |-> ($past(power_good) && (vdd_target >= clk_select)));

  p_clk_down_first_r4: assert property (@(posedge clk) disable iff (rst)
    (vdd_target < $past(vdd_target)) |-> (clk_select == vdd_target));

  p_good_drops_r7: assert property (@(posedge clk) disable iff (rst)
    (vdd_target != $past(vdd_target)) |-> !power_good);

  p_good_from_settle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(power_good) |-> $past(settle_ok));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_not_busy_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind perf_level_sequencer perf_level_sequencer_chk #(.LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .vdd_target (vdd_target),
  .clk_select (clk_select),
  .power_good (power_good),
  .busy       (busy),
  .done       (done),
  .settle_ok  (settle_ok)
);

// File: tb/tb_perf_level_sequencer.sv
module tb_perf_level_sequencer;

  localparam int LVL_W = 3;
  localparam int ERR_W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                    rst;
  logic                    req_valid;
  logic [LVL_W-1:0]        req_level;
  logic                    err_valid;
  logic signed [ERR_W-1:0] err_sample;
  logic [ERR_W-1:0]        settle_window;
  logic [LVL_W-1:0]        vdd_target;
  logic [LVL_W-1:0]        clk_select;
  logic                    power_good;
  logic                    busy;
  logic                    done;

  perf_level_sequencer #(.LVL_W(LVL_W), .ERR_W(ERR_W), .SETTLE_N(4)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .err_valid(err_valid), .err_sample(err_sample), .settle_window(settle_window),
    .vdd_target(vdd_target), .clk_select(clk_select), .power_good(power_good),
    .busy(busy), .done(done)
  );

  int vectors     = 0;
  int miscompares = 0;
  int exp_q[$];
  int popped;
  logic [LVL_W-1:0] prev_clk;
  logic [LVL_W-1:0] prev_vdd;
  logic             prev_pg;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic request(input int lvl, input bit expect_done);
    @(negedge clk);
    req_valid = 1'b1;
    req_level = LVL_W'(lvl);
    if (expect_done) exp_q.push_back(lvl);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R10 done pulse seen", int'(done), 1);
  endtask

  // Monitor: scoreboard pops at each done, ordering checks on every change.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 done without accepted request", 1, 0);
        end else begin
          popped = exp_q.pop_front();
          check(int'(clk_select) == popped, "R3/R5 clk_select at done", int'(clk_select), popped);
          check(int'(vdd_target) == popped, "R3/R5 vdd_target at done", int'(vdd_target), popped);
          check(power_good == 1'b1, "R5 power_good at done", int'(power_good), 1);
        end
      end
      if (clk_select > prev_clk)
        check(prev_pg == 1'b1, "R3 clock raised before power good", int'(prev_pg), 1);
      if (vdd_target < prev_vdd)
        check(clk_select == vdd_target, "R4 voltage lowered before clock", int'(clk_select), int'(vdd_target));
    end
    prev_clk = clk_select;
    prev_vdd = vdd_target;
    prev_pg  = power_good;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_level = '0;
    err_valid = 1'b1; err_sample = 8'sd20; settle_window = 8'd4;
    repeat (3) @(negedge clk);
    check(vdd_target == 0, "R1 vdd_target reset", int'(vdd_target), 0);
    check(clk_select == 0, "R1 clk_select reset", int'(clk_select), 0);
    check(power_good == 1, "R1 power_good reset", int'(power_good), 1);
    check(busy == 0, "R1 busy reset", int'(busy), 0);
    check(done == 0, "R1 done reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(power_good == 1 && busy == 0, "R1 state after release", int'(busy), 0);

    // Rise 0 -> 3 with the loop held out of the window.
    request(3, 1'b1);
    @(negedge clk);
    check(vdd_target == 3, "R2 voltage raised first", int'(vdd_target), 3);
    check(clk_select == 0, "R2 clock held during rise", int'(clk_select), 0);
    check(power_good == 0, "R7 power_good dropped", int'(power_good), 0);
    check(busy == 1, "R10 busy during rise", int'(busy), 1);
    repeat (8) @(negedge clk);
    check(power_good == 0, "R6 no settle out of window", int'(power_good), 0);
    check(clk_select == 0, "R3 clock waits for power good", int'(clk_select), 0);
    err_sample = -8'sd4;  // boundary magnitude, inside
    wait_done();

    // Rise 3 -> 5, a run of in-window samples broken by one outside.
    err_sample = 8'sd20;
    request(5, 1'b1);
    @(negedge clk);
    err_sample = 8'sd3;
    repeat (3) @(negedge clk);
    err_sample = 8'sd5;   // just past the bound
    @(negedge clk);
    err_sample = 8'sd3;
    repeat (2) @(negedge clk);
    err_sample = 8'sd20;
    repeat (3) @(negedge clk);
    check(power_good == 0, "R6 broken run restarts count", int'(power_good), 0);
    check(clk_select == 3, "R6 clock held after broken run", int'(clk_select), 3);
    err_sample = 8'sd0;
    wait_done();

    // Fall 5 -> 1 with a request injected while busy.
    err_sample = 8'sd20;
    request(1, 1'b1);
    @(negedge clk);
    check(clk_select == 1, "R4 clock lowered first", int'(clk_select), 1);
    check(vdd_target == 5, "R4 voltage held one edge", int'(vdd_target), 5);
    @(negedge clk);
    check(vdd_target == 1, "R4 voltage lowered next", int'(vdd_target), 1);
    check(power_good == 0, "R7 power_good dropped on fall", int'(power_good), 0);
    request(6, 1'b0);     // ignored: busy
    err_sample = 8'sd4;   // boundary magnitude, inside
    wait_done();
    repeat (3) @(negedge clk);
    check(busy == 0, "R9 ignored request started nothing", int'(busy), 0);
    check(clk_select == 1, "R9 clock unchanged by ignored request", int'(clk_select), 1);
    check(vdd_target == 1, "R9 voltage unchanged by ignored request", int'(vdd_target), 1);

    // Same-level request.
    request(1, 1'b1);
    wait_done();
    check(clk_select == 1 && vdd_target == 1, "R8 no output change", int'(vdd_target), 1);
    check(power_good == 1, "R8 power_good kept", int'(power_good), 1);
    @(negedge clk);
    check(done == 0, "R10 done is one cycle", int'(done), 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule